// File: doc/BRIEF.md
# Strided RGB Window Multiply-Accumulate Engine

This block computes one output pixel of a strided two-dimensional convolution over three-layer (RGB) signed 8-bit image data. Every operand word is 96 bits wide and carries four neighbouring pixels, each with three colour layers. On every beat the engine multiplies the twelve pixel lanes by the twelve matching weight lanes and adds all the products into a wide running sum. After the whole kernel window has been walked, the engine delivers a single saturated 16-bit result.

An internal sequencer produces the addresses. After a start request it visits the kernel window one row at a time and, within a row, one word at a time. For each beat it drives a pixel-word address into the external line storage and a weight-word address into the weight store. Both stores are expected to return the addressed word on the clock edge after the address appears. The first window beat reloads the accumulator, so windows can follow each other with no clearing step in between. An 11-pixel kernel row needs three words. The lanes of the fourth pixel position in the last word of each row lie outside the kernel and are forced to contribute zero.

Top module: `conv_mac_engine`

## Requirements
- R1: Lane l (0 to 11) of a 96-bit word occupies bits [8l+7:8l] and holds pixel position l/3, colour layer l%3, as a two's-complement int8. Each beat adds the sum of the twelve signed lane products to the running total.
- R2: Let a start be sampled at edge 0. After edge k, for k from 0 to 32, busy is high, wgt_addr equals k, and pix_addr equals line_base + out_x*(STRIDE/4) + (k/3)*LINE_WORDS + (k%3). The row index is k/3 and the word index within the row is k%3.
- R3: The pixel word and the weight word for beat k are taken from the inputs during the cycle after edge k+1, which assumes a read latency of one cycle.
- R4: result_valid rises after edge 34 and stays high for exactly one cycle per accepted start.
- R5: result equals the exact sum of all 363 lane products of the window, clamped to the range -32768 to 32767.
- R6: The first beat of a window discards the previous sum, so a window that starts immediately after another gives its own exact result.
- R7: In the last word of each kernel row, lanes 9 to 11 (pixel position 3, kernel column 11) contribute zero whatever the weight and pixel values.
- R8: A start that arrives while busy is high is ignored. It does not change the address sequence, it adds no result pulse, and it does not change the result.
- R9: During and after reset, busy, result_valid, result, pix_addr and wgt_addr are all zero.
- R10: The running sum is at least 24 bits wide, so partial sums beyond the 16-bit range do not wrap. A window whose final sum fits in 16 bits is reported exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one window (taken only when idle) |
| line_base | input | 16 | Word address of the first kernel row in line storage |
| out_x | input | 16 | Output column index, scaled by the stride in words |
| pix_word | input | 96 | Pixel word returned for the previous pix_addr |
| wgt_word | input | 96 | Weight word returned for the previous wgt_addr |
| busy | output | 1 | High while window addresses are issued |
| pix_addr | output | 16 | Pixel-word read address |
| wgt_addr | output | 6 | Weight-word read address |
| result | output | 16 | Saturated window result |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
Addresses for beat k are due one register after the start edge, which is just after edge k. The bench compares both addresses against the formula one time unit after every edge for beats 0 to 32. The result goes through three registers: the address register, the memory word register, and the accumulator with its output register. Its strobe is therefore due after edge 34. The bench counts edges from the start edge and checks that exactly one strobe arrives at that count, together with the bench's own exact sum, computed with saturation. For back-to-back windows the second start is sampled at the first edge where busy is low. Its strobe is expected 34 edges later, and the two results are compared in order.

// File: rtl/conv_mac_pkg.sv
package conv_mac_pkg;
    localparam int PIX_PER_WORD = 4;
    localparam int LAYERS       = 3;
    localparam int LANE_W       = 8;
    localparam int LANES        = PIX_PER_WORD * LAYERS;
    localparam int WORD_W       = LANES * LANE_W;
    localparam int PROD_W       = 2 * LANE_W;
    localparam int SUM_W        = PROD_W + $clog2(LANES);

    function automatic int safe_clog2(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/conv_win_seq.sv
module conv_win_seq
    import conv_mac_pkg::*;
#(
    parameter int KER_W      = 11,
    parameter int KER_H      = 11,
    parameter int STRIDE     = 4,
    parameter int LINE_WORDS = 57,
    parameter int ADDR_W     = 16,
    parameter int WA_W       = 6,
    parameter int COL_W      = 2,
    parameter int ROW_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] line_base,
    input  logic [ADDR_W-1:0] out_x,
    output logic              busy,
    output logic [ADDR_W-1:0] pix_addr,
    output logic [WA_W-1:0]   wgt_addr,
    output logic              beat_vld,
    output logic              beat_first,
    output logic              beat_last,
    output logic [COL_W-1:0]  beat_col
);
    localparam int WPR          = (KER_W + PIX_PER_WORD - 1) / PIX_PER_WORD;
    localparam int STRIDE_WORDS = STRIDE / PIX_PER_WORD;
    localparam logic [ADDR_W-1:0] SW_L   = ADDR_W'(STRIDE_WORDS);
    localparam logic [ADDR_W-1:0] LINE_L = ADDR_W'(LINE_WORDS);
    localparam logic [COL_W-1:0]  COL_END = COL_W'(WPR - 1);
    localparam logic [ROW_W-1:0]  ROW_END = ROW_W'(KER_H - 1);

    typedef struct packed {
        logic              busy;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [ADDR_W-1:0] row_addr;
        logic [ADDR_W-1:0] pix_addr;
        logic [WA_W-1:0]   wgt_addr;
        logic              bv;
        logic              bf;
        logic              bl;
        logic [COL_W-1:0]  bcol;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [ADDR_W-1:0] win_base;

    always_comb begin
        seq_d    = seq_q;
        win_base = line_base + out_x * SW_L;
        // stage aligned with data returning one cycle after the address
        seq_d.bv   = seq_q.busy;
        seq_d.bf   = seq_q.busy && (seq_q.row == '0) && (seq_q.col == '0);
        seq_d.bl   = seq_q.busy && (seq_q.row == ROW_END) && (seq_q.col == COL_END);
        seq_d.bcol = seq_q.col;
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy     = 1'b1;
                seq_d.row      = '0;
                seq_d.col      = '0;
                seq_d.row_addr = win_base;
                seq_d.pix_addr = win_base;
                seq_d.wgt_addr = '0;
            end
        end else begin
            seq_d.wgt_addr = seq_q.wgt_addr + 1'b1;
            if (seq_q.col == COL_END) begin
                seq_d.col = '0;
                if (seq_q.row == ROW_END) begin
                    seq_d.busy = 1'b0;
                end else begin
                    seq_d.row      = seq_q.row + 1'b1;
                    seq_d.row_addr = seq_q.row_addr + LINE_L;
                    seq_d.pix_addr = seq_q.row_addr + LINE_L;
                end
            end else begin
                seq_d.col      = seq_q.col + 1'b1;
                seq_d.pix_addr = seq_q.pix_addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy       = seq_q.busy;
    assign pix_addr   = seq_q.pix_addr;
    assign wgt_addr   = seq_q.wgt_addr;
    assign beat_vld   = seq_q.bv;
    assign beat_first = seq_q.bf;
    assign beat_last  = seq_q.bl;
    assign beat_col   = seq_q.bcol;
endmodule

// File: rtl/conv_lane_mac.sv
module conv_lane_mac
    import conv_mac_pkg::*;
#(
    parameter int KER_W = 11,
    parameter int COL_W = 2
) (
    input  logic [WORD_W-1:0]       pix_word,
    input  logic [WORD_W-1:0]       wgt_word,
    input  logic [COL_W-1:0]        col,
    output logic signed [SUM_W-1:0] lane_sum
);
    logic signed [PROD_W-1:0] prod [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int PIX_POS = l / LAYERS;
        logic signed [LANE_W-1:0] pa, wb;
        logic signed [PROD_W-1:0] pa_w, wb_w;
        logic                     lane_on;
        assign pa      = pix_word[l*LANE_W +: LANE_W];
        assign wb      = wgt_word[l*LANE_W +: LANE_W];
        assign pa_w    = PROD_W'(pa);
        assign wb_w    = PROD_W'(wb);
        // kernel column of this lane must lie inside the kernel width
        assign lane_on = (int'(col) * PIX_PER_WORD + PIX_POS) < KER_W;
        assign prod[l] = lane_on ? (pa_w * wb_w) : '0;
    end

    always_comb begin
        lane_sum = '0;
        for (int l = 0; l < LANES; l++) begin
            lane_sum = lane_sum + SUM_W'(prod[l]);
        end
    end
endmodule

// File: rtl/conv_acc_sat.sv
module conv_acc_sat
    import conv_mac_pkg::*;
#(
    parameter int ACC_W = 24,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    beat_vld,
    input  logic                    beat_first,
    input  logic                    beat_last,
    input  logic signed [SUM_W-1:0] lane_sum,
    output logic [OUT_W-1:0]        result,
    output logic                    result_valid
);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [OUT_W-1:0]        res;
        logic                    rv;
    } acc_t;

    acc_t acc_d, acc_q;
    logic signed [ACC_W-1:0] nxt;

    always_comb begin
        acc_d    = acc_q;
        acc_d.rv = 1'b0;
        nxt      = beat_first ? ACC_W'(lane_sum) : (acc_q.acc + ACC_W'(lane_sum));
        if (beat_vld) begin
            acc_d.acc = nxt;
            if (beat_last) begin
                acc_d.rv = 1'b1;
                if (nxt > SAT_HI) begin
                    acc_d.res = SAT_HI[OUT_W-1:0];
                end else if (nxt < SAT_LO) begin
                    acc_d.res = SAT_LO[OUT_W-1:0];
                end else begin
                    acc_d.res = nxt[OUT_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign result       = acc_q.res;
    assign result_valid = acc_q.rv;
endmodule

// File: rtl/conv_mac_engine.sv
module conv_mac_engine
    import conv_mac_pkg::*;
#(
    parameter int KER_W      = 11,
    parameter int KER_H      = 11,
    parameter int STRIDE     = 4,
    parameter int LINE_WORDS = 57,
    parameter int ADDR_W     = 16,
    parameter int ACC_W      = 24,
    parameter int OUT_W      = 16,
    localparam int WPR       = (KER_W + PIX_PER_WORD - 1) / PIX_PER_WORD,
    localparam int BEATS     = WPR * KER_H,
    localparam int WA_W      = safe_clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] line_base,
    input  logic [ADDR_W-1:0] out_x,
    input  logic [WORD_W-1:0] pix_word,
    input  logic [WORD_W-1:0] wgt_word,
    output logic              busy,
    output logic [ADDR_W-1:0] pix_addr,
    output logic [WA_W-1:0]   wgt_addr,
    output logic [OUT_W-1:0]  result,
    output logic              result_valid
);
    localparam int COL_W = safe_clog2(WPR);
    localparam int ROW_W = safe_clog2(KER_H);

    logic                    beat_vld, beat_first, beat_last;
    logic [COL_W-1:0]        beat_col;
    logic signed [SUM_W-1:0] lane_sum;

    conv_win_seq #(
        .KER_W(KER_W), .KER_H(KER_H), .STRIDE(STRIDE), .LINE_WORDS(LINE_WORDS),
        .ADDR_W(ADDR_W), .WA_W(WA_W), .COL_W(COL_W), .ROW_W(ROW_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .line_base(line_base), .out_x(out_x),
        .busy(busy), .pix_addr(pix_addr), .wgt_addr(wgt_addr),
        .beat_vld(beat_vld), .beat_first(beat_first), .beat_last(beat_last),
        .beat_col(beat_col)
    );

    conv_lane_mac #(.KER_W(KER_W), .COL_W(COL_W)) u_mac (
        .pix_word(pix_word), .wgt_word(wgt_word), .col(beat_col), .lane_sum(lane_sum)
    );

    conv_acc_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .beat_vld(beat_vld), .beat_first(beat_first),
        .beat_last(beat_last), .lane_sum(lane_sum),
        .result(result), .result_valid(result_valid)
    );
endmodule

// File: rtl/conv_mac_engine_chk.sv
module conv_mac_engine_chk #(
    parameter int BEATS  = 33,
    parameter int ADDR_W = 16,
    parameter int WA_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic [ADDR_W-1:0] pix_addr,
    input logic [WA_W-1:0]   wgt_addr,
    input logic              result_valid
);
    localparam int CNT_W = $clog2(BEATS + 2);
    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(pix_addr) && $stable(wgt_addr)));

    assert_first_wgt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (wgt_addr == '0));

    assert_wgt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (wgt_addr == $past(wgt_addr) + 1'b1));

    assert_beat_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == CNT_W'(BEATS)));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    assert_result_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> result_valid);
endmodule

bind conv_mac_engine conv_mac_engine_chk #(
    .BEATS(BEATS), .ADDR_W(ADDR_W), .WA_W(WA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .pix_addr(pix_addr), .wgt_addr(wgt_addr), .result_valid(result_valid)
);

// File: tb/conv_mac_engine_bench.sv
module conv_mac_engine_bench;
    localparam int KW = 11, KH = 11, LW = 57, SWW = 1, WPR = 3, BEATS = 33;
    localparam int DUE = BEATS + 1;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [15:0] line_base = '0, out_x = '0;
    logic [95:0] pix_word = '0, wgt_word = '0;
    logic        busy, result_valid;
    logic [15:0] pix_addr, result;
    logic [5:0]  wgt_addr;

    logic [95:0] pix_mem [0:1023];
    logic [95:0] wgt_mem [0:63];

    int tests = 0, fails = 0;

    conv_mac_engine u_conv_mac_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .line_base(line_base), .out_x(out_x),
        .pix_word(pix_word), .wgt_word(wgt_word), .busy(busy), .pix_addr(pix_addr),
        .wgt_addr(wgt_addr), .result(result), .result_valid(result_valid)
    );

    always #10 clk = ~clk;

    // storage model: word returned on the edge after the address
    always @(posedge clk) begin
        pix_word <= pix_mem[pix_addr[9:0]];
        wgt_word <= wgt_mem[wgt_addr];
    end

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int expect_win(input int lb, input int ox);
        longint s = 0;
        for (int r = 0; r < KH; r++) begin
            for (int c = 0; c < WPR; c++) begin
                for (int l = 0; l < 12; l++) begin
                    logic signed [7:0] a, b;
                    int addr;
                    addr = lb + ox * SWW + r * LW + c;
                    a = pix_mem[addr][l*8 +: 8];
                    b = wgt_mem[r*WPR + c][l*8 +: 8];
                    if (c * 4 + l / 3 < KW) s += longint'(a) * longint'(b);
                end
            end
        end
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    task automatic fill_const(input logic [7:0] pv, input logic [7:0] wv);
        for (int i = 0; i < 1024; i++) pix_mem[i] = {12{pv}};
        for (int j = 0; j < 64; j++) wgt_mem[j] = {12{wv}};
    endtask

    // launch a window; optionally inject a second start while busy
    task automatic run_window(input int lb, input int ox, input int inj_at,
                              output int got, output int lat, output int npulse,
                              output int addr_err);
        got = 0; lat = -1; npulse = 0; addr_err = 0;
        @(negedge clk);
        line_base = 16'(lb); out_x = 16'(ox); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int k = 0; k < 70; k++) begin
            if (k < BEATS) begin
                if (!busy || wgt_addr != 6'(k) ||
                    pix_addr != 16'(lb + ox * SWW + (k / WPR) * LW + (k % WPR)))
                    addr_err++;
            end
            if (result_valid) begin
                npulse++;
                got = int'($signed(result));
                lat = k;
            end
            if (k == inj_at) begin
                start = 1'b1; out_x = 16'(ox + 5); line_base = 16'(lb + 3);
            end
            if (k == inj_at + 1) start = 1'b0;
            @(posedge clk); #1;
        end
    endtask

    task automatic t_reset;
        chk(busy == 1'b0 && result_valid == 1'b0, "R9", "busy/valid at reset", {busy, result_valid}, 0);
        chk(result == '0 && pix_addr == '0 && wgt_addr == '0, "R9", "result/addresses at reset",
            result + pix_addr + wgt_addr, 0);
    endtask

    task automatic t_ones;
        int got, lat, np, ae;
        fill_const(8'h01, 8'h01);
        run_window(0, 0, -1, got, lat, np, ae);
        chk(ae == 0, "R2", "address sequence ones", ae, 0);
        chk(lat == DUE && np == 1, "R4", "strobe latency", lat, DUE);
        chk(got == 363, "R5", "ones window sum", got, 363);
    endtask

    task automatic t_pattern;
        int got, lat, np, ae, exp;
        for (int i = 0; i < 1024; i++)
            for (int l = 0; l < 12; l++)
                pix_mem[i][l*8 +: 8] = 8'(((i * 29 + l * 13 + 7) % 17) - 8);
        for (int j = 0; j < 64; j++)
            for (int l = 0; l < 12; l++)
                wgt_mem[j][l*8 +: 8] = 8'(((j * 11 + l * 5 + 3) % 17) - 8);
        exp = expect_win(5, 2);
        run_window(5, 2, -1, got, lat, np, ae);
        chk(ae == 0, "R2", "strided address sequence", ae, 0);
        chk(got == exp, "R1", "lane products pattern", got, exp);
        chk(lat == DUE, "R3", "one-cycle read alignment latency", lat, DUE);
    endtask

    task automatic t_mask;
        int got, lat, np, ae;
        fill_const(8'h7F, 8'h00);
        for (int r = 0; r < KH; r++)
            for (int l = 9; l < 12; l++) wgt_mem[r*WPR + 2][l*8 +: 8] = 8'h7F;
        run_window(0, 1, -1, got, lat, np, ae);
        chk(got == 0, "R7", "outside-kernel lanes ignored", got, 0);
    endtask

    task automatic t_sat;
        int got, lat, np, ae;
        fill_const(8'h7F, 8'h7F);
        run_window(0, 0, -1, got, lat, np, ae);
        chk(got == 32767, "R5", "positive clamp", got, 32767);
        fill_const(8'h80, 8'h7F);
        run_window(0, 0, -1, got, lat, np, ae);
        chk(got == -32768, "R5", "negative clamp", got, -32768);
    endtask

    task automatic t_wide_partial;
        int got, lat, np, ae;
        fill_const(8'd100, 8'h00);
        for (int j = 0; j < BEATS; j++)
            wgt_mem[j] = (j / WPR < 5) ? {12{8'd100}} : ((j / WPR < 10) ? {12{8'h9C}} : {12{8'h01}});
        run_window(0, 0, -1, got, lat, np, ae);
        chk(got == 3300, "R10", "large partial sums no wrap", got, 3300);
    endtask

    task automatic t_busy_start;
        int got, lat, np, ae;
        fill_const(8'h02, 8'h03);
        run_window(0, 0, 10, got, lat, np, ae);
        chk(ae == 0, "R8", "address sequence with start while busy", ae, 0);
        chk(np == 1, "R8", "pulse count with start while busy", np, 1);
        chk(got == 2178, "R8", "result with start while busy", got, 2178);
    endtask

    task automatic t_back2back;
        int res [2];
        int n = 0, k = 0;
        for (int i = 0; i < 1024; i++) pix_mem[i] = ((i % LW) < 3) ? {12{8'h7F}} : {12{8'h01}};
        for (int j = 0; j < 64; j++) wgt_mem[j] = {12{8'h01}};
        @(negedge clk);
        line_base = '0; out_x = '0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        while (busy && k < 60) begin @(posedge clk); #1; k++; end
        @(negedge clk);
        out_x = 16'd10; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int c = 0; c < 80; c++) begin
            if (result_valid && n < 2) begin res[n] = int'($signed(result)); n++; end
            @(posedge clk); #1;
        end
        chk(n == 2, "R6", "two results back to back", n, 2);
        chk(res[0] == 32767, "R6", "first window result", res[0], 32767);
        chk(res[1] == 363, "R6", "second window cleared sum", res[1], 363);
    endtask

    initial begin
        fill_const(8'h00, 8'h00);
        repeat (3) @(posedge clk);
        #1;
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        t_ones;
        t_pattern;
        t_mask;
        t_sat;
        t_wide_partial;
        t_busy_start;
        t_back2back;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule